// File: doc/BRIEF.md
# Serial Asynchronous Receiver Channel with Per-Character Status Queue

This block is one receive channel of an asynchronous serial port. A 16x sample tick drives a frame sampler that confirms the start bit at its middle, then takes each data bit, an optional even-parity bit and the stop bit at the centre of the bit. The character it assembles is stored together with three status flags: parity error, framing error and received break. A small queue of three entries holds these, with a single holding stage in front of it. The host sees the oldest entry on its head outputs and removes it with a one-cycle read strobe.

The channel reports whether a character is waiting, whether the queue is full, and a sticky overrun flag. Only an explicit error-reset command clears the overrun flag. A break that begins partway through a character yields two entries: the damaged character and then one all-zero break character. After that the sampler stays silent until the line has been high for half a bit time. A request-to-send output is raised by a host command. When automatic control is on, it drops on the push that fills the queue.

Top module: `serial_rx_channel`

## Requirements
- R1: After reset, rx_ready, fifo_full, overrun and rts_out are all 0.
- R2: With sample_tick active, a frame is a low start bit, DATA_W data bits sent LSB first, one parity bit (PARITY_EN=1) and a stop bit, each 16 ticks long. A valid frame appears as an entry whose head_data equals the bits sent, and entries leave in arrival order.
- R3: rx_ready is 1 exactly when the queue holds at least one entry. fifo_full is 1 exactly when it holds FIFO_DEPTH (3) entries.
- R4: Each entry carries its own flags: head_parity_err when the data bits and parity bit together have an odd number of ones, and head_frame_err when the stop sample is low. host_rd pops the head entry, and a host_rd while the queue is empty changes nothing.
- R5: A character that completes while the queue is full waits in the holding stage and enters the queue on the next read. A character that completes while the queue is full and the holding stage is occupied is lost, and overrun is set.
- R6: overrun stays 1 through reads and is cleared only by clr_err_cmd.
- R7: If the line falls to a continuous low partway through a character, that character is stored with head_frame_err set, holding the bits sampled before the low began.
- R8: If the low then lasts a whole further character time, exactly one entry with head_data 0 and head_break 1 is stored. No further entry arrives until the line has been high for 8 consecutive ticks.
- R9: rts_on_cmd sets rts_out to 1. With rts_auto_en set, rts_out drops to 0 on the push that brings the queue from FIFO_DEPTH-1 to FIFO_DEPTH entries. With rts_auto_en clear, filling the queue leaves rts_out unchanged.
- R10: While rx_enable is 0, no character is assembled, and entries already stored stay readable.
- R11: A low pulse shorter than half a bit time on an idle line is not taken as a start bit and produces no entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sample_tick | input | 1 | 16x oversampling strobe |
| rx_line | input | 1 | Serial receive line, idle high |
| rx_enable | input | 1 | Receiver enable |
| host_rd | input | 1 | Pop the head entry |
| clr_err_cmd | input | 1 | Clear the overrun flag |
| rts_on_cmd | input | 1 | Assert request-to-send |
| rts_auto_en | input | 1 | Drop request-to-send when the queue fills |
| head_data | output | DATA_W | Character of the head entry |
| head_parity_err | output | 1 | Parity flag of the head entry |
| head_frame_err | output | 1 | Framing flag of the head entry |
| head_break | output | 1 | Break flag of the head entry |
| rx_ready | output | 1 | At least one entry waiting |
| fifo_full | output | 1 | All queue entries occupied |
| overrun | output | 1 | Sticky overrun flag |
| rts_out | output | 1 | Request-to-send, 1 = asserted |

## Verification
The assertions assume that host_rd, clr_err_cmd and rts_on_cmd are single-cycle pulses issued while no frame is completing. They also assume each serial bit lasts a whole number of ticks, so the sampler never sees a start edge inside its own stop-bit sample. The stimulus keeps to this. It drives the line only at falling clock edges, with every bit exactly 16 ticks long. It issues host commands only in the idle gap after a frame. For framing-error frames it holds the stop bit low for half a bit only, so that a line kept low does not start a false frame. Random frames draw data, parity faults, stop faults, reads and commands from a fixed seed. Directed cases cover overflow into the holding stage, overrun, the mid-character break, a start glitch and the disabled receiver.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

   typedef enum logic [1:0] {
      RX_IDLE     = 2'd0,
      RX_START    = 2'd1,
      RX_BITS     = 2'd2,
      RX_BRKWAIT  = 2'd3
   } rx_state_e;

   // status flags sit directly above the data bits in each stored entry
   localparam int FLAG_COUNT = 3;
   localparam int FLAG_PERR  = 0;
   localparam int FLAG_FERR  = 1;
   localparam int FLAG_BRK   = 2;

endpackage

// File: rtl/serial_rx_sampler.sv
module serial_rx_sampler
   import serial_rx_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int PARITY_EN   = 1,
   parameter int OVS         = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           tick,
   input  logic                           rxd,
   input  logic                           enable,
   output logic                           out_valid,
   output logic [DATA_W+FLAG_COUNT-1:0]   out_entry
);

   localparam int PAY_W      = DATA_W + PARITY_EN;
   localparam int FRAME_BITS = PAY_W + 1;
   localparam int HALF       = OVS / 2;
   localparam int PH_W       = $clog2(OVS);
   localparam int IDX_W      = $clog2(FRAME_BITS + 1);

   if (OVS < 4 || (OVS & (OVS - 1)) != 0) begin : g_bad_ovs
      $error("OVS must be a power of two of at least 4");
   end
   if (DATA_W < 5 || DATA_W > 9) begin : g_bad_width
      $error("DATA_W must lie in 5..9");
   end
   if (PARITY_EN != 0 && PARITY_EN != 1) begin : g_bad_par
      $error("PARITY_EN must be 0 or 1");
   end

   // line synchronizer, depth chosen by parameter
   logic line_s;
   if (SYNC_STAGES == 0) begin : g_nosync
      assign line_s = rxd;
   end else begin : g_sync
      logic [SYNC_STAGES-1:0] sync_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sync_q <= '1;
         else        sync_q <= {sync_q[SYNC_STAGES-2+1-1:0], rxd} ;
      end
      assign line_s = sync_q[SYNC_STAGES-1];
   end

   rx_state_e          state;
   logic [PH_W-1:0]    phase;
   logic [PH_W-1:0]    hi_cnt;
   logic [IDX_W-1:0]   bit_idx;
   logic [PAY_W-1:0]   shreg;

   // parity variant chosen at elaboration
   logic par_bad;
   if (PARITY_EN != 0) begin : g_par
      assign par_bad = ^shreg;
   end else begin : g_nopar
      assign par_bad = 1'b0;
   end

   logic all_low;
   logic [DATA_W+FLAG_COUNT-1:0] good_entry;
   logic [DATA_W+FLAG_COUNT-1:0] brk_entry;

   assign all_low = (shreg == '0) && !line_s;

   always_comb begin
      good_entry = '0;
      good_entry[DATA_W-1:0]          = shreg[DATA_W-1:0];
      good_entry[DATA_W + FLAG_PERR]  = par_bad;
      good_entry[DATA_W + FLAG_FERR]  = !line_s;
      brk_entry = '0;
      brk_entry[DATA_W + FLAG_BRK]    = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= RX_IDLE;
         phase     <= '0;
         hi_cnt    <= '0;
         bit_idx   <= '0;
         shreg     <= '0;
         out_valid <= 1'b0;
         out_entry <= '0;
      end else begin
         out_valid <= 1'b0;
         if (!enable) begin
            state <= RX_IDLE;
         end else if (tick) begin
            unique case (state)
               RX_IDLE: begin
                  if (!line_s) begin
                     state <= RX_START;
                     phase <= PH_W'(1);
                  end
               end
               RX_START: begin
                  if (phase == PH_W'(HALF - 1)) begin
                     if (!line_s) begin
                        state   <= RX_BITS;
                        phase   <= '0;
                        bit_idx <= '0;
                        shreg   <= '0;
                     end else begin
                        state <= RX_IDLE;
                     end
                  end else begin
                     phase <= phase + PH_W'(1);
                  end
               end
               RX_BITS: begin
                  if (phase == PH_W'(OVS - 1)) begin
                     phase <= '0;
                     if (bit_idx == IDX_W'(FRAME_BITS - 1)) begin
                        out_valid <= 1'b1;
                        if (all_low) begin
                           out_entry <= brk_entry;
                           state     <= RX_BRKWAIT;
                           hi_cnt    <= '0;
                        end else begin
                           out_entry <= good_entry;
                           state     <= RX_IDLE;
                        end
                     end else begin
                        shreg   <= {line_s, shreg[PAY_W-1:1]};
                        bit_idx <= bit_idx + IDX_W'(1);
                     end
                  end else begin
                     phase <= phase + PH_W'(1);
                  end
               end
               RX_BRKWAIT: begin
                  if (!line_s) begin
                     hi_cnt <= '0;
                  end else if (hi_cnt == PH_W'(HALF - 1)) begin
                     state <= RX_IDLE;
                  end else begin
                     hi_cnt <= hi_cnt + PH_W'(1);
                  end
               end
               default: state <= RX_IDLE;
            endcase
         end
      end
   end

   // R8: no character leaves the sampler while it waits out a break
   p_break_silent_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (state == RX_BRKWAIT) |=> !out_valid);

   // R10: a disabled receiver produces nothing
   p_disabled_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!enable && state == RX_IDLE) |=> !out_valid);

   // R11: a start edge that is high again at mid-bit is dropped
   p_glitch_reject_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && tick && state == RX_START && phase == PH_W'(HALF - 1) && line_s)
         |=> (state == RX_IDLE));

endmodule

// File: rtl/serial_rx_fifo.sv
module serial_rx_fifo #(
   parameter int W     = 11,
   parameter int DEPTH = 3
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           push,
   input  logic [W-1:0]                   push_data,
   input  logic                           pop,
   output logic [W-1:0]                   head,
   output logic                           empty,
   output logic                           full,
   output logic [$clog2(DEPTH+1)-1:0]     count
);

   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CNT_W = $clog2(DEPTH + 1);

   if (DEPTH < 1) begin : g_bad_depth
      $error("DEPTH must be at least 1");
   end

   logic [W-1:0]     mem [DEPTH];
   logic [PTR_W-1:0] wr_ptr;
   logic [PTR_W-1:0] rd_ptr;
   logic             do_pop;

   function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
      return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
   endfunction

   assign empty  = (count == '0);
   assign full   = (count == CNT_W'(DEPTH));
   assign do_pop = pop && !empty;
   assign head   = mem[rd_ptr];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else begin
         if (push) begin
            mem[wr_ptr] <= push_data;
            wr_ptr      <= ptr_next(wr_ptr);
         end
         if (do_pop) rd_ptr <= ptr_next(rd_ptr);
         if (push && !do_pop)      count <= count + CNT_W'(1);
         else if (!push && do_pop) count <= count - CNT_W'(1);
      end
   end

   // R5: the front end never writes into a full queue without a read
   p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (push && full) |-> pop);

   // R4: a read of an empty queue leaves it empty
   p_empty_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && empty && !push) |=> (count == '0));

endmodule

// File: rtl/serial_rx_flow.sv
module serial_rx_flow #(
   parameter int W     = 11,
   parameter int DEPTH = 3
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           in_valid,
   input  logic [W-1:0]                   in_entry,
   input  logic                           q_full,
   input  logic [$clog2(DEPTH+1)-1:0]     q_count,
   input  logic                           q_pop,
   input  logic                           clr_err,
   input  logic                           rts_on,
   input  logic                           rts_auto,
   output logic                           push,
   output logic [W-1:0]                   push_entry,
   output logic                           overrun,
   output logic                           rts
);

   localparam int CNT_W = $clog2(DEPTH + 1);

   logic         hold_v;
   logic [W-1:0] hold_e;
   logic         space;
   logic         lost;
   logic         fill_evt;

   assign space      = !q_full || q_pop;
   assign push       = hold_v ? space : (in_valid && space);
   assign push_entry = hold_v ? hold_e : in_entry;
   assign lost       = in_valid && hold_v && !space;
   assign fill_evt   = push && !q_pop && (q_count == CNT_W'(DEPTH - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_v  <= 1'b0;
         hold_e  <= '0;
         overrun <= 1'b0;
         rts     <= 1'b0;
      end else begin
         if (hold_v) begin
            if (space) begin
               if (in_valid) hold_e <= in_entry;
               else          hold_v <= 1'b0;
            end
         end else if (in_valid && !space) begin
            hold_e <= in_entry;
            hold_v <= 1'b1;
         end

         if (lost)         overrun <= 1'b1;
         else if (clr_err) overrun <= 1'b0;

         if (rts_auto && fill_evt) rts <= 1'b0;
         else if (rts_on)          rts <= 1'b1;
      end
   end

   // R6: overrun persists until the clear command
   p_overrun_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (overrun && !clr_err) |=> overrun);

   // R9: filling the queue under automatic control negates RTS
   p_rts_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (rts_auto && fill_evt) |=> !rts);

   // R5: the holding stage is used only behind a full queue
   p_hold_behind_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
      hold_v |-> q_full);

endmodule

// File: rtl/serial_rx_channel.sv
module serial_rx_channel
   import serial_rx_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int PARITY_EN   = 1,
   parameter int OVS         = 16,
   parameter int SYNC_STAGES = 2,
   parameter int FIFO_DEPTH  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sample_tick,
   input  logic              rx_line,
   input  logic              rx_enable,
   input  logic              host_rd,
   input  logic              clr_err_cmd,
   input  logic              rts_on_cmd,
   input  logic              rts_auto_en,
   output logic [DATA_W-1:0] head_data,
   output logic              head_parity_err,
   output logic              head_frame_err,
   output logic              head_break,
   output logic              rx_ready,
   output logic              fifo_full,
   output logic              overrun,
   output logic              rts_out
);

   localparam int ENT_W = DATA_W + FLAG_COUNT;
   localparam int CNT_W = $clog2(FIFO_DEPTH + 1);

   logic             s_valid;
   logic [ENT_W-1:0] s_entry;
   logic             q_push;
   logic [ENT_W-1:0] q_wdata;
   logic [ENT_W-1:0] q_head;
   logic             q_empty;
   logic             q_full;
   logic [CNT_W-1:0] q_count;
   logic             q_pop;

   serial_rx_sampler #(
      .DATA_W      (DATA_W),
      .PARITY_EN   (PARITY_EN),
      .OVS         (OVS),
      .SYNC_STAGES (SYNC_STAGES)
   ) u_sampler (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (sample_tick),
      .rxd       (rx_line),
      .enable    (rx_enable),
      .out_valid (s_valid),
      .out_entry (s_entry)
   );

   assign q_pop = host_rd && !q_empty;

   serial_rx_flow #(
      .W     (ENT_W),
      .DEPTH (FIFO_DEPTH)
   ) u_flow (
      .clk        (clk),
      .rst_n      (rst_n),
      .in_valid   (s_valid),
      .in_entry   (s_entry),
      .q_full     (q_full),
      .q_count    (q_count),
      .q_pop      (q_pop),
      .clr_err    (clr_err_cmd),
      .rts_on     (rts_on_cmd),
      .rts_auto   (rts_auto_en),
      .push       (q_push),
      .push_entry (q_wdata),
      .overrun    (overrun),
      .rts        (rts_out)
   );

   serial_rx_fifo #(
      .W     (ENT_W),
      .DEPTH (FIFO_DEPTH)
   ) u_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (q_push),
      .push_data (q_wdata),
      .pop       (host_rd),
      .head      (q_head),
      .empty     (q_empty),
      .full      (q_full),
      .count     (q_count)
   );

   assign head_data       = q_head[DATA_W-1:0];
   assign head_parity_err = q_head[DATA_W + FLAG_PERR];
   assign head_frame_err  = q_head[DATA_W + FLAG_FERR];
   assign head_break      = q_head[DATA_W + FLAG_BRK];
   assign rx_ready        = !q_empty;
   assign fifo_full       = q_full;

   // R3: a full queue always reports a waiting character
   p_ready_when_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_full |-> rx_ready);

endmodule

// File: tb/test_serial_rx_channel.sv
module test_serial_rx_channel;

   localparam int DW  = 8;
   localparam int BIT = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          sample_tick = 1'b1;
   logic          rx_line = 1'b1;
   logic          rx_enable = 1'b1;
   logic          host_rd = 1'b0;
   logic          clr_err_cmd = 1'b0;
   logic          rts_on_cmd = 1'b0;
   logic          rts_auto_en = 1'b0;
   logic [DW-1:0] head_data;
   logic          head_parity_err, head_frame_err, head_break;
   logic          rx_ready, fifo_full, overrun, rts_out;

   always #4 clk = ~clk;

   serial_rx_channel i_serial_rx_channel (
      .clk (clk), .rst_n (rst_n), .sample_tick (sample_tick), .rx_line (rx_line),
      .rx_enable (rx_enable), .host_rd (host_rd), .clr_err_cmd (clr_err_cmd),
      .rts_on_cmd (rts_on_cmd), .rts_auto_en (rts_auto_en),
      .head_data (head_data), .head_parity_err (head_parity_err),
      .head_frame_err (head_frame_err), .head_break (head_break),
      .rx_ready (rx_ready), .fifo_full (fifo_full), .overrun (overrun),
      .rts_out (rts_out)
   );

   int vectors = 0;
   int errors  = 0;
   bit done    = 0;

   // model: entry = {brk, ferr, perr, data}
   logic [DW+2:0] mq[$];
   logic          m_hold_v = 0;
   logic [DW+2:0] m_hold;
   logic          m_ovr = 0;
   logic          m_rts = 0;

   function automatic logic [DW+2:0] mk(input logic [DW-1:0] d, input bit pe,
                                        input bit fe, input bit br);
      return {br, fe, pe, d};
   endfunction

   task automatic chk(input string req, input string what, input int act, input int exp);
      vectors++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic model_push(input logic [DW+2:0] e);
      if (mq.size() < 3) begin
         mq.push_back(e);
         if (mq.size() == 3 && rts_auto_en) m_rts = 0;
      end else if (!m_hold_v) begin
         m_hold = e;
         m_hold_v = 1;
      end else begin
         m_ovr = 1;
      end
   endtask

   task automatic check_all(input string req);
      chk(req, "rx_ready", int'(rx_ready), int'(mq.size() > 0));
      chk(req, "fifo_full", int'(fifo_full), int'(mq.size() == 3));
      chk(req, "overrun", int'(overrun), int'(m_ovr));
      chk(req, "rts_out", int'(rts_out), int'(m_rts));
      if (mq.size() > 0) begin
         chk(req, "head_data", int'(head_data), int'(mq[0][DW-1:0]));
         chk(req, "head_parity_err", int'(head_parity_err), int'(mq[0][DW]));
         chk(req, "head_frame_err", int'(head_frame_err), int'(mq[0][DW+1]));
         chk(req, "head_break", int'(head_break), int'(mq[0][DW+2]));
      end
   endtask

   task automatic hold_line(input logic v, input int n);
      rx_line = v;
      repeat (n) @(negedge clk);
   endtask

   task automatic send_frame(input logic [DW-1:0] d, input bit bad_par, input bit bad_stop);
      hold_line(1'b0, BIT);
      for (int i = 0; i < DW; i++) hold_line(d[i], BIT);
      hold_line((^d) ^ bad_par, BIT);
      if (bad_stop) begin
         hold_line(1'b0, BIT / 2);
         hold_line(1'b1, BIT / 2);
      end else begin
         hold_line(1'b1, BIT);
      end
      hold_line(1'b1, 24);
      if (rx_enable) model_push(mk(d, bad_par, bad_stop, 1'b0));
   endtask

   task automatic host_read();
      host_rd = 1'b1;
      @(negedge clk);
      host_rd = 1'b0;
      if (mq.size() > 0) begin
         void'(mq.pop_front());
         if (m_hold_v) begin
            mq.push_back(m_hold);
            m_hold_v = 0;
         end
      end
      @(negedge clk);
   endtask

   task automatic pulse_clr();
      clr_err_cmd = 1'b1;
      @(negedge clk);
      clr_err_cmd = 1'b0;
      m_ovr = 0;
      @(negedge clk);
   endtask

   task automatic pulse_rts();
      rts_on_cmd = 1'b1;
      @(negedge clk);
      rts_on_cmd = 1'b0;
      m_rts = 1;
      @(negedge clk);
   endtask

   task automatic report();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         report();
      end
   end

   initial begin
      logic [DW-1:0] rd;
      bit rp, rs;
      process::self().srandom(32'd5150);
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      check_all("R1");

      // R2: plain frame
      send_frame(8'h55, 0, 0);
      check_all("R2");
      send_frame(8'hA3, 0, 0);
      check_all("R2");
      host_read(); check_all("R2");
      host_read(); check_all("R2");

      // R4: per-entry flags and empty read
      send_frame(8'h3C, 1, 0);
      send_frame(8'hF1, 0, 1);
      check_all("R4");
      host_read(); check_all("R4");
      host_read(); check_all("R4");
      host_read(); check_all("R4");

      // R11: short glitch
      hold_line(1'b0, 4);
      hold_line(1'b1, 200);
      check_all("R11");

      // R9 / R3 / R5 / R6: fill, hold, overrun
      rts_auto_en = 1'b1;
      pulse_rts(); check_all("R9");
      send_frame(8'h11, 0, 0);
      send_frame(8'h22, 0, 0); check_all("R9");
      send_frame(8'h33, 0, 0); check_all("R3");
      send_frame(8'h44, 0, 0); check_all("R5");
      send_frame(8'h55, 0, 0); check_all("R5");
      host_read(); check_all("R6");
      host_read(); check_all("R5");
      host_read(); check_all("R5");
      host_read(); check_all("R6");
      pulse_clr(); check_all("R6");
      rts_auto_en = 1'b0;

      // R9: no auto, full queue keeps RTS
      pulse_rts();
      send_frame(8'h01, 0, 0);
      send_frame(8'h02, 0, 0);
      send_frame(8'h03, 0, 0); check_all("R9");
      host_read(); host_read(); host_read(); check_all("R9");

      // R10: disabled receiver
      send_frame(8'h7E, 0, 0);
      rx_enable = 1'b0;
      send_frame(8'h81, 0, 0);
      check_all("R10");
      host_read(); check_all("R10");
      rx_enable = 1'b1;
      hold_line(1'b1, 8);

      // R7 / R8: break beginning inside a character
      hold_line(1'b0, BIT);
      hold_line(1'b1, 3 * BIT);
      hold_line(1'b0, (DW - 3 + 2) * BIT + 2 * (DW + 3) * BIT);
      hold_line(1'b1, 48);
      model_push(mk(8'h07, 1, 1, 0));
      model_push(mk(8'h00, 0, 0, 1));
      check_all("R7");
      host_read(); check_all("R8");
      host_read(); check_all("R8");
      send_frame(8'h9D, 0, 0); check_all("R8");
      host_read(); check_all("R8");

      // random mix
      for (int n = 0; n < 40; n++) begin
         rd = DW'($urandom);
         rp = ($urandom % 8) == 0;
         rs = ($urandom % 8) == 0;
         if (rs && !rp && rd == '0) rd = 8'h01;
         rts_auto_en = $urandom % 2;
         if (($urandom % 6) == 0) pulse_rts();
         send_frame(rd, rp, rs);
         check_all(rs ? "R4" : "R2");
         for (int k = 0; k < int'($urandom % 3); k++) begin
            host_read();
            check_all("R5");
         end
         if (($urandom % 5) == 0) begin
            pulse_clr();
            check_all("R6");
         end
      end
      done = 1;
      report();
   end

endmodule